// File: doc/BRIEF.md
# Strap-Configured Host Bus Adapter

This block connects an external microprocessor bus to an internal port that is one word (16 bits) wide. Strap inputs pick the bus style. The strobes can be a separate read strobe and write strobe, or a single data strobe with a read/write select line. The data strobe can be active low or active high. The bus can be 8 or 16 bits wide. In 8-bit mode the order of the two bytes within a word is selectable. The address comes either from dedicated address pins or from the data bus, where two latch enables capture it one byte at a time.

Each strobe assertion is detected at its active edge in the clock domain. It produces a one-cycle internal access pulse. The pulse carries a word address, byte enables, write data and a window flag. The flag is RAM when both memory selects are active, and register when the register select pair is active. Read data returned by the internal side is held and driven back onto the bus while the read strobe stays active. In 8-bit mode, two byte writes are merged into one word write.

Top module: `hostbus_adapter`

## Requirements
- R1: With `strobe_mode`=0, `rd_n`=0 is a read and `wr_n`=0 is a write. Each strobe assertion yields exactly one `acc_valid` pulse, one cycle long, in the cycle after the first clock edge that sees the strobe active. Holding the strobe produces no further pulses.
- R2: With `strobe_mode`=1, `rd_n` is the data strobe. `wr_n`=1 at the active edge makes a read and `wr_n`=0 makes a write.
- R3: `ds_active_high`=0 makes the data strobe active at 0. `ds_active_high`=1 makes it active at 1.
- R4: `mem_sel_n`=2'b00 gives a RAM access (`acc_ram`=1). `per_sel_n`=0 together with `per_sel`=1 gives a register access (`acc_reg`=1). RAM wins when both are true. When neither is true, there is no pulse and `data_oe` stays 0.
- R5: With `bus_wide`=1, `acc_addr`=A[15:1], `acc_be[0]`=~A[0], `acc_be[1]`=~`bhe_n`, and `acc_wdata`=`data_in`.
- R6: With `bus_wide`=0, the byte lane is A[0] XOR `hi_first`, where lane 1 is bits 15:8. A read has `acc_be` one-hot on that lane. It returns that lane's byte on `data_out[7:0]`, with `data_out[15:8]`=0.
- R7: With `bus_wide`=0, a write with A[0]=0 only stores its byte and issues no access. A write with A[0]=1 issues one word write with `acc_be`=2'b11: its own byte goes in its lane, the stored byte goes in the other lane, and the address is that of the second write.
- R8: With `addr_mux`=1, the low address byte follows `data_in[7:0]` while `ale_lo`=1 and is held while it is 0. The high byte works the same way with `data_in[15:8]` and `ale_hi`. `addr_in` is ignored.
- R9: `acc_rdata` is captured on the clock edge after a read pulse and is driven on `data_out`. `data_oe` is 1 while a read strobe is active in a selected window.
- R10: While `rst_n`=0, `acc_valid`=0 and the held read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_mode | input | 1 | 0: separate strobes, 1: data strobe plus read/write line |
| ds_active_high | input | 1 | Data strobe polarity |
| bus_wide | input | 1 | 0: 8-bit bus, 1: 16-bit bus |
| hi_first | input | 1 | 8-bit byte order |
| addr_mux | input | 1 | Take the address from the data bus |
| ale_lo | input | 1 | Low address byte latch enable |
| ale_hi | input | 1 | High address byte latch enable |
| addr_in | input | AW | Separate address pins |
| data_in | input | 16 | Bus data in |
| data_out | output | 16 | Bus read data |
| data_oe | output | 1 | Bus output enable |
| rd_n | input | 1 | Read strobe or data strobe |
| wr_n | input | 1 | Write strobe or read/write select |
| bhe_n | input | 1 | Upper byte enable, active low |
| mem_sel_n | input | 2 | RAM selects, both active low |
| per_sel_n | input | 1 | Register select, active low |
| per_sel | input | 1 | Register select, active high |
| acc_valid | output | 1 | Internal access pulse |
| acc_write | output | 1 | Access is a write |
| acc_ram | output | 1 | Access targets RAM |
| acc_reg | output | 1 | Access targets registers |
| acc_addr | output | AW-1 | Word address |
| acc_be | output | 2 | Byte enables |
| acc_wdata | output | 16 | Write data |
| acc_rdata | input | 16 | Read data from the internal side |

## Verification
If the stored strobe level is wrong, pulses go missing or repeat within one cycle of the strobe edge, so `acc_valid` is visible as wrong at once. If the stored byte or the lane choice is wrong, the merged `acc_wdata` or `data_out` shows it at the second byte write or one edge after a read pulse. If the address latch holds the wrong value, `acc_addr` is wrong on the first access after the latch enables fall.

// File: rtl/hb_pkg.sv
package hb_pkg;
   localparam int BW = 8;
   localparam int DW = 2 * BW;
   typedef enum logic [1:0] {WIN_NONE, WIN_RAM, WIN_REG} win_e;
endpackage

// File: rtl/hb_strobe_decode.sv
module hb_strobe_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_mode,
   input  logic ds_active_high,
   input  logic rd_n,
   input  logic wr_n,
   output logic active,
   output logic is_wr,
   output logic start
);
   logic active_q;

   always_comb begin
      if (strobe_mode) begin
         active = ds_active_high ? rd_n : ~rd_n;
         is_wr  = ~wr_n;
      end else begin
         active = ~rd_n | ~wr_n;
         is_wr  = ~wr_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active;
   end

   assign start = active & ~active_q;
endmodule

// File: rtl/hb_addr_latch.sv
module hb_addr_latch #(
   parameter int AW = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  addr_mux,
   input  logic                  ale_lo,
   input  logic                  ale_hi,
   input  logic [AW-1:0]         addr_in,
   input  logic [hb_pkg::DW-1:0] data_in,
   output logic [AW-1:0]         eff_addr
);
   import hb_pkg::*;
   localparam int HW = AW - BW;

   if (AW <= BW || AW > DW) begin : g_bad_aw
      initial $fatal(1, "hb_addr_latch: AW must lie in %0d..%0d", BW + 1, DW);
   end

   logic [BW-1:0] lat_lo;
   logic [HW-1:0] lat_hi;
   logic [BW-1:0] cur_lo;
   logic [HW-1:0] cur_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_lo <= '0;
         lat_hi <= '0;
      end else begin
         if (ale_lo) lat_lo <= data_in[BW-1:0];
         if (ale_hi) lat_hi <= data_in[BW+HW-1:BW];
      end
   end

   assign cur_lo   = ale_lo ? data_in[BW-1:0]       : lat_lo;
   assign cur_hi   = ale_hi ? data_in[BW+HW-1:BW]   : lat_hi;
   assign eff_addr = addr_mux ? {cur_hi, cur_lo} : addr_in;
endmodule

// File: rtl/hb_lane_pack.sv
module hb_lane_pack #(
   parameter int AW = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wide,
   input  logic                  hi_first,
   input  logic                  start,
   input  logic                  is_wr,
   input  hb_pkg::win_e          win,
   input  logic [AW-1:0]         eff_addr,
   input  logic                  bhe_n,
   input  logic [hb_pkg::DW-1:0] data_in,
   input  logic [hb_pkg::DW-1:0] acc_rdata,
   output logic                  acc_valid,
   output logic                  acc_write,
   output logic                  acc_ram,
   output logic                  acc_reg,
   output logic [AW-2:0]         acc_addr,
   output logic [1:0]            acc_be,
   output logic [hb_pkg::DW-1:0] acc_wdata,
   output logic [hb_pkg::DW-1:0] data_out
);
   import hb_pkg::*;
   localparam int LANES = DW / BW;

   logic [BW-1:0] held_byte;
   logic [DW-1:0] rd_hold;
   logic          rd_lane;
   logic          rd_wide;
   logic          lane_cur;
   logic [DW-1:0] merged;
   logic [1:0]    lane_be;

   assign lane_cur = eff_addr[0] ^ hi_first;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[i*BW +: BW] = (lane_cur == i[0]) ? data_in[BW-1:0] : held_byte;
      assign lane_be[i]         = (lane_cur == i[0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_write <= 1'b0;
         acc_ram   <= 1'b0;
         acc_reg   <= 1'b0;
         acc_addr  <= '0;
         acc_be    <= '0;
         acc_wdata <= '0;
         held_byte <= '0;
         rd_hold   <= '0;
         rd_lane   <= 1'b0;
         rd_wide   <= 1'b1;
      end else begin
         acc_valid <= 1'b0;
         if (acc_valid && !acc_write) rd_hold <= acc_rdata;
         if (start && win != WIN_NONE) begin
            acc_ram <= (win == WIN_RAM);
            acc_reg <= (win == WIN_REG);
            if (bus_wide) begin
               acc_valid <= 1'b1;
               acc_write <= is_wr;
               acc_addr  <= eff_addr[AW-1:1];
               acc_be    <= {~bhe_n, ~eff_addr[0]};
               acc_wdata <= data_in;
               rd_wide   <= 1'b1;
            end else if (is_wr && !eff_addr[0]) begin
               held_byte <= data_in[BW-1:0];
            end else begin
               acc_valid <= 1'b1;
               acc_write <= is_wr;
               acc_addr  <= eff_addr[AW-1:1];
               acc_be    <= is_wr ? 2'b11 : lane_be;
               acc_wdata <= merged;
               rd_wide   <= 1'b0;
               rd_lane   <= lane_cur;
            end
         end
      end
   end

   assign data_out = rd_wide ? rd_hold
                   : {{BW{1'b0}}, rd_lane ? rd_hold[DW-1:BW] : rd_hold[BW-1:0]};
endmodule

// File: rtl/hostbus_adapter.sv
module hostbus_adapter #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe_mode,
   input  logic          ds_active_high,
   input  logic          bus_wide,
   input  logic          hi_first,
   input  logic          addr_mux,
   input  logic          ale_lo,
   input  logic          ale_hi,
   input  logic [AW-1:0] addr_in,
   input  logic [15:0]   data_in,
   output logic [15:0]   data_out,
   output logic          data_oe,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          bhe_n,
   input  logic [1:0]    mem_sel_n,
   input  logic          per_sel_n,
   input  logic          per_sel,
   output logic          acc_valid,
   output logic          acc_write,
   output logic          acc_ram,
   output logic          acc_reg,
   output logic [AW-2:0] acc_addr,
   output logic [1:0]    acc_be,
   output logic [15:0]   acc_wdata,
   input  logic [15:0]   acc_rdata
);
   import hb_pkg::*;

   logic          active;
   logic          is_wr;
   logic          start;
   logic [AW-1:0] eff_addr;
   win_e          win;

   always_comb begin
      if (mem_sel_n == 2'b00)       win = WIN_RAM;
      else if (!per_sel_n && per_sel) win = WIN_REG;
      else                          win = WIN_NONE;
   end

   hb_strobe_decode u_strobe (
      .clk(clk), .rst_n(rst_n), .strobe_mode(strobe_mode),
      .ds_active_high(ds_active_high), .rd_n(rd_n), .wr_n(wr_n),
      .active(active), .is_wr(is_wr), .start(start)
   );

   hb_addr_latch #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .addr_mux(addr_mux), .ale_lo(ale_lo),
      .ale_hi(ale_hi), .addr_in(addr_in), .data_in(data_in), .eff_addr(eff_addr)
   );

   hb_lane_pack #(.AW(AW)) u_pack (
      .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .hi_first(hi_first),
      .start(start), .is_wr(is_wr), .win(win), .eff_addr(eff_addr),
      .bhe_n(bhe_n), .data_in(data_in), .acc_rdata(acc_rdata),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_ram(acc_ram),
      .acc_reg(acc_reg), .acc_addr(acc_addr), .acc_be(acc_be),
      .acc_wdata(acc_wdata), .data_out(data_out)
   );

   assign data_oe = active & ~is_wr & (win != WIN_NONE);
endmodule

// File: rtl/hb_checker.sv
module hb_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wide,
   input logic       bhe_n,
   input logic       strobe_mode,
   input logic       rd_n,
   input logic       acc_valid,
   input logic       acc_write,
   input logic       acc_ram,
   input logic       acc_reg,
   input logic [1:0] acc_be,
   input logic       data_oe
);
   // R1
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> !acc_valid);

   // R4
   window_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({acc_ram, acc_reg}));

   // R4
   window_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (acc_ram || acc_reg));

   // R7
   byte_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !$past(bus_wide)) |-> acc_be == 2'b11);

   // R5
   upper_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && $past(bus_wide)) |-> acc_be[1] == !$past(bhe_n));

   // R9
   drive_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && !strobe_mode) |-> !rd_n);
endmodule

bind hostbus_adapter hb_checker u_hb_checker (
   .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .bhe_n(bhe_n),
   .strobe_mode(strobe_mode), .rd_n(rd_n), .acc_valid(acc_valid),
   .acc_write(acc_write), .acc_ram(acc_ram), .acc_reg(acc_reg),
   .acc_be(acc_be), .data_oe(data_oe)
);

// File: tb/hostbus_adapter_bench.sv
module hostbus_adapter_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strobe_mode = 1'b0, ds_active_high = 1'b0, bus_wide = 1'b1;
   logic        hi_first = 1'b0, addr_mux = 1'b0, ale_lo = 1'b0, ale_hi = 1'b0;
   logic [15:0] addr_in = '0, data_in = '0;
   logic [15:0] data_out;
   logic        data_oe;
   logic        rd_n = 1'b1, wr_n = 1'b1, bhe_n = 1'b1;
   logic [1:0]  mem_sel_n = 2'b11;
   logic        per_sel_n = 1'b1, per_sel = 1'b0;
   logic        acc_valid, acc_write, acc_ram, acc_reg;
   logic [14:0] acc_addr;
   logic [1:0]  acc_be;
   logic [15:0] acc_wdata, acc_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [15:0] model(input logic [14:0] wa);
      return {wa[7:0] ^ 8'h5A, wa[14:7]};
   endfunction

   assign acc_rdata = model(acc_addr);

   hostbus_adapter u_hostbus_adapter (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic ds, input logic pol, input logic wide,
                           input logic hf, input logic mx);
      @(negedge clk);
      strobe_mode = ds; ds_active_high = pol; bus_wide = wide;
      hi_first = hf; addr_mux = mx;
      rd_n = (ds && pol) ? 1'b0 : 1'b1;
      wr_n = 1'b1;
   endtask

   task automatic drive_strobe(input logic on, input logic wr);
      if (!strobe_mode) begin
         rd_n = !(on && !wr);
         wr_n = !(on && wr);
      end else begin
         wr_n = on ? !wr : 1'b1;
         rd_n = ds_active_high ? on : !on;
      end
   endtask

   task automatic do_acc(input logic wr, input logic [1:0] sel, input logic [15:0] a,
                         input logic [15:0] d, input logic bhe, input logic expv,
                         input logic [1:0] ebe, input logic [14:0] eaddr,
                         input logic [15:0] ew, input logic [15:0] erd, input string tag);
      @(negedge clk);
      if (addr_mux) begin
         data_in = a; ale_lo = 1'b1; ale_hi = 1'b1;
         @(negedge clk);
         ale_lo = 1'b0; ale_hi = 1'b0; addr_in = 16'hFFFF;
      end else begin
         addr_in = a;
      end
      data_in   = d;
      bhe_n     = bhe;
      mem_sel_n = (sel == 2'd1 || sel == 2'd3) ? 2'b00 : 2'b11;
      per_sel_n = !(sel == 2'd2 || sel == 2'd3);
      per_sel   = (sel == 2'd2 || sel == 2'd3);
      drive_strobe(1'b1, wr);
      @(posedge clk); #1;
      chk({tag, " valid"}, {31'b0, acc_valid}, {31'b0, expv});
      if (expv) begin
         chk({tag, " write"}, {31'b0, acc_write}, {31'b0, wr});
         chk({tag, " R4 win"}, {30'b0, acc_ram, acc_reg},
             {30'b0, sel[0], sel == 2'd2});
         chk({tag, " addr"}, {17'b0, acc_addr}, {17'b0, eaddr});
         chk({tag, " be"}, {30'b0, acc_be}, {30'b0, ebe});
         if (wr) chk({tag, " wdata"}, {16'b0, acc_wdata}, {16'b0, ew});
      end
      @(posedge clk); #1;
      // R1: a held strobe issues no second pulse
      chk({tag, " R1 no repeat"}, {31'b0, acc_valid}, 32'b0);
      chk({tag, " R9 oe"}, {31'b0, data_oe}, {31'b0, expv && !wr});
      if (expv && !wr) chk({tag, " R9 rdata"}, {16'b0, data_out}, {16'b0, erd});
      @(negedge clk);
      drive_strobe(1'b0, 1'b0);
      mem_sel_n = 2'b11; per_sel_n = 1'b1; per_sel = 1'b0;
      @(negedge clk);
   endtask

   // {strobe_mode, ds_active_high, write, sel[1:0], bhe_n, addr[15:0], data[15:0]}
   localparam logic [37:0] VEC [8] = '{
      {1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 16'h1234, 16'hBEEF},
      {1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 16'h0040, 16'h0000},
      {1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 16'h0100, 16'hCAFE},
      {1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 16'h0A0A, 16'h0000},
      {1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 16'h0033, 16'h5555},
      {1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 16'h7FFE, 16'h0000},
      {1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 16'h0002, 16'h1111},
      {1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 16'h0004, 16'h0000}
   };

   initial begin
      repeat (2) @(posedge clk);
      #1;
      // R10
      chk("R10 reset valid", {31'b0, acc_valid}, 32'b0);
      chk("R10 reset data", {16'b0, data_out}, 32'b0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 8; i++) begin
         logic [37:0] v;
         string tag;
         v = VEC[i];
         tag = v[37] ? (v[36] ? "R2 R3 hi" : "R2 R3 lo") : "R1";
         if (v[34:33] == 2'd0) tag = {tag, " R4 none"};
         set_mode(v[37], v[36], 1'b1, 1'b0, 1'b0);
         do_acc(v[35], v[34:33], v[31:16], v[15:0], v[32], v[34:33] != 2'd0,
                {~v[32], ~v[16]}, v[31:17], v[15:0], model(v[31:17]), {tag, " R5"});
      end

      // R7 and R6, low byte first
      set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      do_acc(1'b1, 2'd1, 16'h0010, 16'h00AB, 1'b1, 1'b0, 2'b00, 15'h0, 16'h0, 16'h0, "R7 first");
      do_acc(1'b1, 2'd1, 16'h0011, 16'h00CD, 1'b1, 1'b1, 2'b11, 15'h0008, 16'hCDAB, 16'h0, "R7 merge");
      do_acc(1'b0, 2'd1, 16'h0011, 16'h0000, 1'b1, 1'b1, 2'b10, 15'h0008, 16'h0,
             {8'h00, model(15'h0008)[15:8]}, "R6 lo-first odd");
      do_acc(1'b0, 2'd2, 16'h0010, 16'h0000, 1'b1, 1'b1, 2'b01, 15'h0008, 16'h0,
             {8'h00, model(15'h0008)[7:0]}, "R6 lo-first even");

      // R7 and R6, high byte first
      set_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      do_acc(1'b1, 2'd1, 16'h0020, 16'h0012, 1'b1, 1'b0, 2'b00, 15'h0, 16'h0, 16'h0, "R7 hf first");
      do_acc(1'b1, 2'd1, 16'h0021, 16'h0034, 1'b1, 1'b1, 2'b11, 15'h0010, 16'h1234, 16'h0, "R7 hf merge");
      do_acc(1'b0, 2'd1, 16'h0020, 16'h0000, 1'b1, 1'b1, 2'b10, 15'h0010, 16'h0,
             {8'h00, model(15'h0010)[15:8]}, "R6 hi-first even");

      // R8 multiplexed address
      set_mode(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      do_acc(1'b1, 2'd1, 16'h2468, 16'h9999, 1'b0, 1'b1, 2'b11, 15'h1234, 16'h9999, 16'h0, "R8 mux wr");
      do_acc(1'b0, 2'd2, 16'hA5C3, 16'h0000, 1'b1, 1'b1, 2'b00, 15'h52E1, 16'h0,
             model(15'h52E1), "R8 mux rd");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=hung exp=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule